// File: doc/BRIEF.md
# Speculative Cache Line State Tracker

This block keeps the speculative bookkeeping for a small direct-mapped data cache that runs threads under thread-level speculation. Every line holds a tag, a coherence state (invalid, shared, exclusive or dirty), a read-under-speculation bit and a written-under-speculation bit. A single request channel brings in processor loads and stores, coherence invalidations stamped with the writer's epoch, and snoop reads from other caches. Two commands, squash and commit, rewrite every line in one cycle.

The tracker detects reads that ran ahead of an older writer. An invalidation from a logically earlier epoch that hits a line read under speculation sets a sticky violation flag. Losing speculative state by replacing a line also sets the flag. On commit, written lines that already hold ownership become dirty. Written lines held shared are marked as needing ownership, and an acknowledge input later turns them dirty. A lookup port lets the cache controller read any line's tag, state and speculative bits. Data storage, the bus engine and memory sit outside this block.

Top module: `spec_line_tracker`

## Requirements
- R1: With `spec_mode` high, a load sets the line's `lk_sl` bit and a store sets its `lk_sm` bit. A store that hits a shared line leaves it shared. A store or load miss fills the line as shared (`lk_state`=1) when `req_shared` is high and as exclusive (2) otherwise. Ops on `req_op`: 0 load, 1 store, 2 invalidate, 3 snoop read. States: 0 invalid, 1 shared, 2 exclusive, 3 dirty.
- R2: With `spec_mode` low, no speculative bit is set and `violation` never rises. A non-speculative store leaves the line dirty, and a non-speculative invalidation always makes the line invalid.
- R3: An invalidation that hits a line with `lk_sl` set raises `violation` when the request epoch is earlier than the local epoch. Earlier means that `req_tid` equals `local_tid` and that (`req_seq` - `local_seq`) modulo 2^SEQ_W has its top bit set. This ordering works across wrap-around. A later epoch or a different thread identifier raises nothing. `violation` stays set until a squash.
- R4: In speculative mode, a tag-matching invalidation makes a line without `lk_sm` invalid and clears its bits. A line with `lk_sm` keeps its tag and bits and becomes shared. An invalidation whose tag misses changes nothing.
- R5: A squash makes every line with `lk_sm` set invalid, clears every speculative bit and clears `violation`, all in one cycle.
- R6: A commit turns every line with `lk_sm` set in exclusive or dirty state into dirty and clears every speculative bit in one cycle.
- R7: A commit sets `own_need[i]` for every line i with `lk_sm` set in shared state. A later `own_ack_valid` for that index makes the line dirty and clears `own_need[i]`.
- R8: In speculative mode, a load or store miss that replaces a valid line holding either speculative bit raises `violation`.
- R9: A snoop read that hits raises `snp_shared` in the same cycle. `snp_supply` is high only when the line is dirty and `lk_sm` is clear. An exclusive or dirty line becomes shared, while a line with `lk_sm` set keeps that bit.
- R10: In a squash or commit cycle, `stall` is high and any request or ownership acknowledge in that cycle has no effect. Squash takes priority over commit.
- R11: After reset, every line reads back invalid with tag 0 and both bits clear, and `violation` and `own_need` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| spec_mode | input | 1 | Local thread is running speculatively |
| local_tid | input | TID_W | Thread identifier of the local epoch |
| local_seq | input | SEQ_W | Sequence number of the local epoch |
| req_valid | input | 1 | Request present |
| req_op | input | 2 | 0 load, 1 store, 2 invalidate, 3 snoop read |
| req_idx | input | IDX_W | Line index |
| req_tag | input | TAG_W | Address tag |
| req_shared | input | 1 | Fill arrives shared instead of exclusive |
| req_tid | input | TID_W | Writer thread identifier (invalidate) |
| req_seq | input | SEQ_W | Writer sequence number (invalidate) |
| squash | input | 1 | Flash squash command |
| commit | input | 1 | Flash commit command |
| own_ack_valid | input | 1 | Ownership granted for a pending line |
| own_ack_idx | input | IDX_W | Index of the granted line |
| lk_idx | input | IDX_W | Lookup index |
| stall | output | 1 | Requests this cycle are refused |
| violation | output | 1 | Sticky speculation failure flag |
| snp_shared | output | 1 | Snoop hit, answer shared |
| snp_supply | output | 1 | Snoop hit on clean-of-speculation dirty data |
| own_need | output | LINES | Lines awaiting ownership after commit |
| lk_tag | output | TAG_W | Tag of the looked-up line |
| lk_state | output | 2 | Coherence state of the looked-up line |
| lk_sl | output | 1 | Read-under-speculation bit |
| lk_sm | output | 1 | Written-under-speculation bit |

## Verification
The bench targets epoch ordering at the sequence wrap point. A design using an unsigned compare would miss the violation from sequence 250 against local 2, or would report one for the reverse case. It also sends invalidations with a different thread identifier and with a missing tag, which a careless design would treat as a violation or an invalidation. Commit is checked on exclusive, dirty and shared written lines. Mixing these up shows as a shared line turned dirty without ownership, or as a missing `own_need` bit. Requests and an acknowledge sent during command cycles, a snoop of a dirty line that holds speculative data, and the eviction of a written line all expose designs that act on stalled input, leak speculative data or lose speculative state silently.

// File: rtl/spt_pkg.sv
package spt_pkg;
  typedef enum logic [1:0] {
    LS_INV = 2'd0,
    LS_SHR = 2'd1,
    LS_EXC = 2'd2,
    LS_DRT = 2'd3
  } line_st_e;

  typedef enum logic [1:0] {
    OP_LOAD  = 2'd0,
    OP_STORE = 2'd1,
    OP_INV   = 2'd2,
    OP_SNOOP = 2'd3
  } req_op_e;
endpackage

// File: rtl/spt_epoch_cmp.sv
module spt_epoch_cmp #(
  parameter int TID_W = 4,
  parameter int SEQ_W = 8
) (
  input  logic [TID_W-1:0] a_tid,
  input  logic [SEQ_W-1:0] a_seq,
  input  logic [TID_W-1:0] b_tid,
  input  logic [SEQ_W-1:0] b_seq,
  output logic             a_before_b
);
  logic [SEQ_W-1:0] seq_diff;

  // modular difference: top bit set means a lies behind b (wrap-safe)
  always_comb begin
    seq_diff   = a_seq - b_seq;
    a_before_b = (a_tid == b_tid) && seq_diff[SEQ_W-1];
  end
endmodule

// File: rtl/spt_line_slot.sv
module spt_line_slot
  import spt_pkg::*;
#(
  parameter int TAG_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sel,
  input  req_op_e          op,
  input  logic [TAG_W-1:0] req_tag,
  input  logic             req_shared,
  input  logic             spec_mode,
  input  logic             inv_earlier,
  input  logic             do_squash,
  input  logic             do_commit,
  input  logic             ack_sel,
  output line_st_e         st_q,
  output logic [TAG_W-1:0] tag_q,
  output logic             sl_q,
  output logic             sm_q,
  output logic             pend_q,
  output logic             hit,
  output logic             viol_ev,
  output logic             evict_ev
);
  line_st_e         st_d;
  logic [TAG_W-1:0] tag_d;
  logic             sl_d, sm_d, pend_d, upd;

  assign hit = (st_q != LS_INV) && (tag_q == req_tag);
  assign upd = sel | ack_sel | do_squash | do_commit;

  always_comb begin
    st_d     = st_q;
    tag_d    = tag_q;
    sl_d     = sl_q;
    sm_d     = sm_q;
    pend_d   = pend_q;
    viol_ev  = 1'b0;
    evict_ev = 1'b0;
    if (do_squash) begin
      if (sm_q) begin
        st_d   = LS_INV;
        pend_d = 1'b0;
      end
      sl_d = 1'b0;
      sm_d = 1'b0;
    end else if (do_commit) begin
      if (sm_q) begin
        if (st_q == LS_SHR) pend_d = 1'b1;
        else                st_d   = LS_DRT;
      end
      sl_d = 1'b0;
      sm_d = 1'b0;
    end else begin
      if (ack_sel && pend_q && (st_q == LS_SHR)) begin
        st_d   = LS_DRT;
        pend_d = 1'b0;
      end
      if (sel) begin
        unique case (op)
          OP_LOAD, OP_STORE: begin
            if (!hit) begin
              evict_ev = spec_mode && (st_q != LS_INV) && (sl_q || sm_q);
              tag_d    = req_tag;
              pend_d   = 1'b0;
              sl_d     = spec_mode && (op == OP_LOAD);
              sm_d     = spec_mode && (op == OP_STORE);
              if (!spec_mode && (op == OP_STORE)) st_d = LS_DRT;
              else st_d = req_shared ? LS_SHR : LS_EXC;
            end else if (op == OP_LOAD) begin
              sl_d = sl_q | spec_mode;
            end else if (spec_mode) begin
              sm_d = 1'b1;
            end else begin
              st_d   = LS_DRT;
              pend_d = 1'b0;
            end
          end
          OP_INV: begin
            if (hit) begin
              viol_ev = spec_mode && sl_q && inv_earlier;
              if (spec_mode && sm_q) begin
                st_d = LS_SHR;
              end else begin
                st_d   = LS_INV;
                sl_d   = 1'b0;
                sm_d   = 1'b0;
                pend_d = 1'b0;
              end
            end
          end
          default: begin
            if (hit && ((st_q == LS_EXC) || (st_q == LS_DRT))) st_d = LS_SHR;
          end
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= LS_INV;
      tag_q  <= '0;
      sl_q   <= 1'b0;
      sm_q   <= 1'b0;
      pend_q <= 1'b0;
    end else if (upd) begin
      st_q   <= st_d;
      tag_q  <= tag_d;
      sl_q   <= sl_d;
      sm_q   <= sm_d;
      pend_q <= pend_d;
    end
  end
endmodule

// File: rtl/spec_line_tracker.sv
module spec_line_tracker
  import spt_pkg::*;
#(
  parameter int LINES = 16,
  parameter int TAG_W = 8,
  parameter int TID_W = 4,
  parameter int SEQ_W = 8,
  localparam int IDX_W = $clog2(LINES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             spec_mode,
  input  logic [TID_W-1:0] local_tid,
  input  logic [SEQ_W-1:0] local_seq,
  input  logic             req_valid,
  input  logic [1:0]       req_op,
  input  logic [IDX_W-1:0] req_idx,
  input  logic [TAG_W-1:0] req_tag,
  input  logic             req_shared,
  input  logic [TID_W-1:0] req_tid,
  input  logic [SEQ_W-1:0] req_seq,
  input  logic             squash,
  input  logic             commit,
  input  logic             own_ack_valid,
  input  logic [IDX_W-1:0] own_ack_idx,
  input  logic [IDX_W-1:0] lk_idx,
  output logic             stall,
  output logic             violation,
  output logic             snp_shared,
  output logic             snp_supply,
  output logic [LINES-1:0] own_need,
  output logic [TAG_W-1:0] lk_tag,
  output logic [1:0]       lk_state,
  output logic             lk_sl,
  output logic             lk_sm
);
  req_op_e          op;
  logic             go, inv_earlier, viol_d;
  line_st_e         st_a  [LINES];
  logic [TAG_W-1:0] tag_a [LINES];
  logic [LINES-1:0] sl_vec, sm_vec, hit_vec, vev, eev;

  assign op    = req_op_e'(req_op);
  assign stall = squash | commit;          // R10: one-cycle flash window
  assign go    = req_valid & ~stall;

  spt_epoch_cmp #(.TID_W(TID_W), .SEQ_W(SEQ_W)) u_cmp (
    .a_tid      (req_tid),
    .a_seq      (req_seq),
    .b_tid      (local_tid),
    .b_seq      (local_seq),
    .a_before_b (inv_earlier)
  );

  for (genvar i = 0; i < LINES; i++) begin : g_line
    spt_line_slot #(.TAG_W(TAG_W)) u_slot (
      .clk         (clk),
      .rst_n       (rst_n),
      .sel         (go && (req_idx == IDX_W'(i))),
      .op          (op),
      .req_tag     (req_tag),
      .req_shared  (req_shared),
      .spec_mode   (spec_mode),
      .inv_earlier (inv_earlier),
      .do_squash   (squash),
      .do_commit   (commit & ~squash),
      .ack_sel     (own_ack_valid && !stall && (own_ack_idx == IDX_W'(i))),
      .st_q        (st_a[i]),
      .tag_q       (tag_a[i]),
      .sl_q        (sl_vec[i]),
      .sm_q        (sm_vec[i]),
      .pend_q      (own_need[i]),
      .hit         (hit_vec[i]),
      .viol_ev     (vev[i]),
      .evict_ev    (eev[i])
    );
  end

  // sticky failure flag, cleared only by squash
  always_comb begin
    viol_d = violation | (|vev) | (|eev);
    if (squash) viol_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) violation <= 1'b0;
    else        violation <= viol_d;
  end

  always_comb begin
    snp_shared = go && (op == OP_SNOOP) && hit_vec[req_idx];
    snp_supply = snp_shared && (st_a[req_idx] == LS_DRT) && !sm_vec[req_idx];
    lk_tag     = tag_a[lk_idx];
    lk_state   = st_a[lk_idx];
    lk_sl      = sl_vec[lk_idx];
    lk_sm      = sm_vec[lk_idx];
  end
endmodule

// File: rtl/spt_checker.sv
module spt_checker #(
  parameter int LINES = 16,
  localparam int IDX_W = $clog2(LINES)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             spec_mode,
  input logic             squash,
  input logic             commit,
  input logic             stall,
  input logic             violation,
  input logic             snp_shared,
  input logic             snp_supply,
  input logic             own_ack_valid,
  input logic [IDX_W-1:0] own_ack_idx,
  input logic [LINES-1:0] own_need,
  input logic [LINES-1:0] sl_vec,
  input logic [LINES-1:0] sm_vec
);
  AST_VIOL_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    violation && !squash |=> violation);                                 // R3
  AST_SQUASH_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    squash |=> !violation && (sm_vec == '0) && (sl_vec == '0));          // R5
  AST_COMMIT_FLASH: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> (sm_vec == '0) && (sl_vec == '0));                        // R6
  AST_ACK_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
    own_ack_valid && !stall && own_need[own_ack_idx] |=> !own_need[$past(own_ack_idx)]); // R7
  AST_NONSPEC_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !spec_mode && !violation |=> !violation);                            // R2
  AST_SUPPLY_SHARED: assert property (@(posedge clk) disable iff (!rst_n)
    snp_supply |-> snp_shared);                                          // R9
  AST_STALL_NO_SNOOP: assert property (@(posedge clk) disable iff (!rst_n)
    stall |-> !snp_shared);                                              // R10
endmodule

bind spec_line_tracker spt_checker #(.LINES(LINES)) u_spt_checker (
  .clk           (clk),
  .rst_n         (rst_n),
  .spec_mode     (spec_mode),
  .squash        (squash),
  .commit        (commit),
  .stall         (stall),
  .violation     (violation),
  .snp_shared    (snp_shared),
  .snp_supply    (snp_supply),
  .own_ack_valid (own_ack_valid),
  .own_ack_idx   (own_ack_idx),
  .own_need      (own_need),
  .sl_vec        (sl_vec),
  .sm_vec        (sm_vec)
);

// File: tb/test_spec_line_tracker.sv
`timescale 1ns/1ps
module test_spec_line_tracker;
  localparam int LINES = 16;
  localparam int TAG_W = 8;
  localparam int TID_W = 4;
  localparam int SEQ_W = 8;
  localparam int IDX_W = 4;

  logic             clk = 1'b0;
  logic             rst_n;
  logic             spec_mode;
  logic [TID_W-1:0] local_tid;
  logic [SEQ_W-1:0] local_seq;
  logic             req_valid;
  logic [1:0]       req_op;
  logic [IDX_W-1:0] req_idx;
  logic [TAG_W-1:0] req_tag;
  logic             req_shared;
  logic [TID_W-1:0] req_tid;
  logic [SEQ_W-1:0] req_seq;
  logic             squash, commit, own_ack_valid;
  logic [IDX_W-1:0] own_ack_idx, lk_idx;
  logic             stall, violation, snp_shared, snp_supply;
  logic [LINES-1:0] own_need;
  logic [TAG_W-1:0] lk_tag;
  logic [1:0]       lk_state;
  logic             lk_sl, lk_sm;

  spec_line_tracker #(.LINES(LINES), .TAG_W(TAG_W), .TID_W(TID_W), .SEQ_W(SEQ_W)) i_spec_line_tracker (
    .clk(clk), .rst_n(rst_n), .spec_mode(spec_mode), .local_tid(local_tid), .local_seq(local_seq),
    .req_valid(req_valid), .req_op(req_op), .req_idx(req_idx), .req_tag(req_tag),
    .req_shared(req_shared), .req_tid(req_tid), .req_seq(req_seq), .squash(squash),
    .commit(commit), .own_ack_valid(own_ack_valid), .own_ack_idx(own_ack_idx), .lk_idx(lk_idx),
    .stall(stall), .violation(violation), .snp_shared(snp_shared), .snp_supply(snp_supply),
    .own_need(own_need), .lk_tag(lk_tag), .lk_state(lk_state), .lk_sl(lk_sl), .lk_sm(lk_sm)
  );

  always #10 clk = ~clk;

  int    checks = 0;
  int    errors = 0;
  int    roll = 0;
  bit    done = 1'b0;
  string cur = "R11";

  // behavioural reference state
  int m_st [LINES];
  int m_tg [LINES];
  bit m_sl [LINES];
  bit m_sm [LINES];
  bit m_pd [LINES];
  bit m_viol;

  task automatic chk(string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", cur, what, act, exp);
    end
  endtask

  function automatic bit m_earlier(int tid, int seq);
    int d;
    if (tid != int'(local_tid)) return 1'b0;
    d = (seq - int'(local_seq)) % 256;
    if (d < 0) d += 256;
    return d >= 128;
  endfunction

  task automatic model_update();
    if (squash) begin
      for (int i = 0; i < LINES; i++) begin
        if (m_sm[i]) begin m_st[i] = 0; m_pd[i] = 0; end
        m_sl[i] = 0; m_sm[i] = 0;
      end
      m_viol = 0;
    end else if (commit) begin
      for (int i = 0; i < LINES; i++) begin
        if (m_sm[i]) begin
          if (m_st[i] == 1) m_pd[i] = 1; else m_st[i] = 3;
        end
        m_sl[i] = 0; m_sm[i] = 0;
      end
    end else begin
      if (own_ack_valid && m_pd[own_ack_idx] && m_st[own_ack_idx] == 1) begin
        m_st[own_ack_idx] = 3; m_pd[own_ack_idx] = 0;
      end
      if (req_valid) begin
        int x; bit h; bit sp;
        x  = int'(req_idx);
        h  = (m_st[x] != 0) && (m_tg[x] == int'(req_tag));
        sp = spec_mode;
        if (req_op == 0 || req_op == 1) begin
          if (!h) begin
            if (sp && m_st[x] != 0 && (m_sl[x] || m_sm[x])) m_viol = 1;
            m_tg[x] = int'(req_tag); m_pd[x] = 0;
            m_sl[x] = sp && req_op == 0;
            m_sm[x] = sp && req_op == 1;
            if (!sp && req_op == 1) m_st[x] = 3;
            else m_st[x] = req_shared ? 1 : 2;
          end else if (req_op == 0) begin
            if (sp) m_sl[x] = 1;
          end else if (sp) begin
            m_sm[x] = 1;
          end else begin
            m_st[x] = 3; m_pd[x] = 0;
          end
        end else if (req_op == 2) begin
          if (h) begin
            if (sp && m_sl[x] && m_earlier(int'(req_tid), int'(req_seq))) m_viol = 1;
            if (sp && m_sm[x]) m_st[x] = 1;
            else begin m_st[x] = 0; m_sl[x] = 0; m_sm[x] = 0; m_pd[x] = 0; end
          end
        end else begin
          if (h && (m_st[x] == 2 || m_st[x] == 3)) m_st[x] = 1;
        end
      end
    end
  endtask

  // compare against the model in the middle of the cycle, then advance one clock
  task automatic step();
    int exp_sh, exp_sup, need;
    #2;
    exp_sh  = (req_valid && !(squash || commit) && req_op == 3 &&
               m_st[req_idx] != 0 && m_tg[req_idx] == int'(req_tag)) ? 1 : 0;
    exp_sup = (exp_sh == 1 && m_st[req_idx] == 3 && !m_sm[req_idx]) ? 1 : 0;
    need = 0;
    for (int i = 0; i < LINES; i++) if (m_pd[i]) need |= (1 << i);
    chk("stall", int'(stall), int'(squash | commit));
    chk("snp_shared", int'(snp_shared), exp_sh);
    chk("snp_supply", int'(snp_supply), exp_sup);
    chk("violation", int'(violation), int'(m_viol));
    chk("own_need", int'(own_need), need);
    lk_idx = IDX_W'(roll);
    #1;
    chk("lk_state", int'(lk_state), m_st[roll]);
    chk("lk_tag", int'(lk_tag), m_tg[roll]);
    chk("lk_sl", int'(lk_sl), int'(m_sl[roll]));
    chk("lk_sm", int'(lk_sm), int'(m_sm[roll]));
    roll = (roll + 1) % LINES;
    model_update();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic idle_in();
    req_valid = 0; req_op = 0; req_idx = 0; req_tag = 0; req_shared = 0;
    req_tid = 0; req_seq = 0; squash = 0; commit = 0; own_ack_valid = 0; own_ack_idx = 0;
  endtask

  task automatic drive(int op, int idx, int tag, bit sh, int tid, int seq);
    req_valid = 1; req_op = 2'(op); req_idx = IDX_W'(idx); req_tag = TAG_W'(tag);
    req_shared = sh; req_tid = TID_W'(tid); req_seq = SEQ_W'(seq);
  endtask

  task automatic ld(int idx, int tag, bit sh);
    drive(0, idx, tag, sh, 0, 0); step(); idle_in();
  endtask
  task automatic st(int idx, int tag, bit sh);
    drive(1, idx, tag, sh, 0, 0); step(); idle_in();
  endtask
  task automatic inv(int idx, int tag, int tid, int seq);
    drive(2, idx, tag, 0, tid, seq); step(); idle_in();
  endtask
  task automatic snoop(int idx, int tag, int esh, int esup);
    drive(3, idx, tag, 0, 0, 0);
    #1;
    chk("snoop shared", int'(snp_shared), esh);
    chk("snoop supply", int'(snp_supply), esup);
    step(); idle_in();
  endtask
  task automatic peek(int idx, int est, int etag, int esl, int esm);
    lk_idx = IDX_W'(idx);
    #1;
    chk($sformatf("line%0d state", idx), int'(lk_state), est);
    chk($sformatf("line%0d tag", idx), int'(lk_tag), etag);
    chk($sformatf("line%0d sl", idx), int'(lk_sl), esl);
    chk($sformatf("line%0d sm", idx), int'(lk_sm), esm);
  endtask

  initial begin
    for (int i = 0; i < LINES; i++) begin
      m_st[i] = 0; m_tg[i] = 0; m_sl[i] = 0; m_sm[i] = 0; m_pd[i] = 0;
    end
    m_viol = 0;
    rst_n = 0; spec_mode = 0; local_tid = 3; local_seq = 10; lk_idx = 0;
    idle_in();
    repeat (3) @(negedge clk);
    rst_n = 1;

    cur = "R11";
    for (int i = 0; i < LINES; i++) peek(i, 0, 0, 0, 0);
    chk("violation", int'(violation), 0);
    chk("own_need", int'(own_need), 0);

    cur = "R1"; spec_mode = 1;
    ld(1, 'h11, 0);  peek(1, 2, 'h11, 1, 0);
    st(2, 'h22, 1);  peek(2, 1, 'h22, 0, 1);
    ld(2, 'h22, 0);  peek(2, 1, 'h22, 1, 1);

    cur = "R2"; spec_mode = 0;
    ld(3, 'h33, 0);  peek(3, 2, 'h33, 0, 0);
    st(4, 'h44, 0);  peek(4, 3, 'h44, 0, 0);
    inv(1, 'h11, 3, 9);
    peek(1, 0, 'h11, 0, 0);
    chk("violation", int'(violation), 0);

    cur = "R3"; spec_mode = 1;
    ld(5, 'h55, 0);  inv(5, 'h55, 3, 12);
    chk("later epoch violation", int'(violation), 0);
    ld(5, 'h55, 0);  inv(5, 'h55, 4, 5);
    chk("other thread violation", int'(violation), 0);
    ld(6, 'h66, 0);
    ld(5, 'h55, 0);  inv(5, 'h55, 3, 9);
    chk("earlier epoch violation", int'(violation), 1);
    step();
    chk("sticky violation", int'(violation), 1);

    cur = "R5";
    squash = 1; step(); idle_in();
    chk("violation after squash", int'(violation), 0);
    peek(2, 0, 'h22, 0, 0);
    peek(6, 2, 'h66, 0, 0);

    cur = "R3"; local_seq = 250;
    ld(10, 'hA0, 0); inv(10, 'hA0, 3, 2);
    chk("wrap later violation", int'(violation), 0);
    local_seq = 2;
    ld(10, 'hA0, 0); inv(10, 'hA0, 3, 250);
    chk("wrap earlier violation", int'(violation), 1);
    squash = 1; step(); idle_in();

    cur = "R4";
    st(7, 'h77, 0);  peek(7, 2, 'h77, 0, 1);
    inv(7, 'h77, 3, 12);
    peek(7, 1, 'h77, 0, 1);
    chk("violation", int'(violation), 0);
    ld(8, 'h88, 0);  inv(8, 'h99, 3, 0);
    peek(8, 2, 'h88, 1, 0);

    cur = "R6";
    st(9, 'h9A, 0);
    st(4, 'h44, 0);  peek(4, 3, 'h44, 0, 1);
    cur = "R10";
    commit = 1; drive(0, 11, 'hBB, 0, 0, 0); step(); idle_in();
    peek(11, 0, 0, 0, 0);
    cur = "R6";
    peek(9, 3, 'h9A, 0, 0);
    peek(4, 3, 'h44, 0, 0);
    peek(8, 2, 'h88, 0, 0);
    cur = "R7";
    peek(7, 1, 'h77, 0, 0);
    chk("own_need after commit", int'(own_need), 'h80);
    cur = "R10";
    squash = 1; own_ack_valid = 1; own_ack_idx = 7; step(); idle_in();
    chk("own_need after stalled ack", int'(own_need), 'h80);
    cur = "R7";
    own_ack_valid = 1; own_ack_idx = 7; step(); idle_in();
    chk("own_need after ack", int'(own_need), 0);
    peek(7, 3, 'h77, 0, 0);

    cur = "R9";
    snoop(9, 'h9A, 1, 1);   peek(9, 1, 'h9A, 0, 0);
    st(8, 'h88, 0);
    snoop(8, 'h88, 1, 0);   peek(8, 1, 'h88, 0, 1);
    snoop(11, 'hBB, 0, 0);
    st(4, 'h44, 0);
    snoop(4, 'h44, 1, 0);   peek(4, 1, 'h44, 0, 1);

    cur = "R8";
    ld(8, 'h18, 0);
    chk("eviction violation", int'(violation), 1);
    squash = 1; step(); idle_in();

    cur = "R2";
    st(12, 'hC0, 0);
    spec_mode = 0;
    ld(12, 'hC1, 0);
    chk("non-spec eviction violation", int'(violation), 0);
    peek(12, 2, 'hC1, 0, 0);
    step();

    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    #2000000;
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog expired during %s", cur);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule